// File: doc/BRIEF.md
# Transmitter PHY Power Sequencer

This block steps a serial video transmitter PHY through power-up and power-down in a fixed order, one control change per state. When a start command is accepted in idle, it captures an 8-bit PHY type code. The code selects two things: the polarity of the PHY reset pin, and whether the low-power retention line is driven. The sequencer holds the PHY in reset for a length of time that depends on the PHY generation. During that reset window it raises the retention line. It then releases reset and hands the configuration phase to an external configuration master through a one-cycle request and a done strobe. Finally it powers the transmitter and waits for PLL lock.

A stop command in the powered state reverses the power controls. The sequencer then waits for the transmitter-ready indication to fall. Only after that may the retention line drop, and only if the drop-enable input is high. Both the lock wait and the ready wait are bounded by counters. An unknown type code, or an expired wait, sets a sticky error flag and returns the sequencer to idle.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset the outputs are: phy_rst 0, tx_pwr_on 0, pddq 1, svsret 0, cfg_req 0, powered 0, busy 0 and err 0.
- R2: For an accepted start, the changes happen one per cycle in this order: reset asserted and busy high, svsret low, svsret set for the type, reset released together with cfg_req, then (after cfg_done) pddq low, then tx_pwr_on high, then powered once pll_lock is seen.
- R3: svsret has its final level at least one cycle before the cycle in which reset is released.
- R4: Type 0x00 is generation 1 and has an active-low reset pin. All other supported types are generation 2 and have an active-high pin. The pin reaches its released level HOLD_G1+4 or HOLD_G2+4 cycles after busy rises.
- R5: Types 0xB2, 0xC2 and 0xF3 drive svsret high during power-up. Types 0x00, 0xE2 and 0xF2 leave it low.
- R6: A start in idle with any type other than 0x00, 0xB2, 0xC2, 0xE2, 0xF2 or 0xF3 (0xFE included) sets err, leaves busy low, and changes no PHY control and no captured type.
- R7: cfg_req is high for exactly one cycle, and the sequence does not continue until cfg_done is seen.
- R8: tx_pwr_on rises only after pddq is low. While powered, tx_pwr_on is high and pddq is low.
- R9: If pll_lock is not seen, err rises and the PHY is powered off (tx_pwr_on 0, pddq 1) LOCK_WAIT+1 cycles after tx_pwr_on rises.
- R10: A stop in the powered state drops tx_pwr_on, then raises pddq, then waits for tx_ready low before returning to idle. svsret falls at that return only when ret_drop_en is high, and otherwise stays high.
- R11: If tx_ready stays high, err rises and the sequencer returns to idle READY_WAIT+1 cycles after pddq rises.
- R12: start and stop are ignored while busy, start is ignored while powered, and stop is ignored in idle. busy and powered are never both high.
- R13: err stays high until a start with a supported type is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Power-up command |
| stop | input | 1 | Power-down command |
| type_id | input | 8 | PHY type code, captured on an accepted start |
| pll_lock | input | 1 | PHY PLL locked |
| tx_ready | input | 1 | PHY transmitter ready |
| cfg_done | input | 1 | Configuration master finished |
| ret_drop_en | input | 1 | Allow svsret to fall at the end of power-down |
| phy_rst | output | 1 | PHY reset pin, with generation-dependent polarity |
| tx_pwr_on | output | 1 | Transmitter power-on |
| pddq | output | 1 | PHY power-down |
| svsret | output | 1 | Retention line; low selects low-power mode |
| cfg_req | output | 1 | One-cycle configuration request |
| powered | output | 1 | Power-up complete |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Sticky error flag |

## Verification
Every control step takes effect one clock after the state that owns it. The order of changes can therefore be checked without fixing absolute times. The bench queues the expected vector of all outputs for each change. A monitor at the falling edge pops one entry each time the vector moves, so an extra, missing or reordered step is reported. Three timing results are measured directly in cycles from the monitor's timestamps: the reset release at hold+4 cycles after busy rises, the lock timeout at LOCK_WAIT+1 cycles after tx_pwr_on rises, and the ready timeout at READY_WAIT+1 cycles after pddq rises.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int HOLD_G1    = 4,
  parameter int HOLD_G2    = 6,
  parameter int LOCK_WAIT  = 20,
  parameter int READY_WAIT = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic [7:0] type_id,
  input  logic       pll_lock,
  input  logic       tx_ready,
  input  logic       cfg_done,
  input  logic       ret_drop_en,
  output logic       phy_rst,
  output logic       tx_pwr_on,
  output logic       pddq,
  output logic       svsret,
  output logic       cfg_req,
  output logic       powered,
  output logic       busy,
  output logic       err
);

  localparam int M1   = (HOLD_G1 > HOLD_G2) ? HOLD_G1 : HOLD_G2;
  localparam int M2   = (LOCK_WAIT > READY_WAIT) ? LOCK_WAIT : READY_WAIT;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_TXOFF, S_PDON, S_RETLO, S_HOLD, S_REL, S_CFGW,
    S_TXON, S_LOCK, S_ON, S_DNPD, S_DNWAIT
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          rst_on, gen1_q, ret_use_q;
  logic          id_ok, id_ret, id_g1, go;

  assign id_g1  = (type_id == 8'h00);
  assign id_ret = (type_id == 8'hB2) || (type_id == 8'hC2) || (type_id == 8'hF3);
  assign id_ok  = id_g1 || id_ret || (type_id == 8'hE2) || (type_id == 8'hF2);
  assign go     = (st == S_IDLE) && start;

  assign phy_rst = rst_on ^ gen1_q;
  assign powered = (st == S_ON);
  assign busy    = (st != S_IDLE) && (st != S_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rst_on    <= 1'b0;
      gen1_q    <= 1'b0;
      ret_use_q <= 1'b0;
      tx_pwr_on <= 1'b0;
      pddq      <= 1'b1;
      svsret    <= 1'b0;
      cfg_req   <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          if (id_ok) begin
            gen1_q    <= id_g1;
            ret_use_q <= id_ret;
            rst_on    <= 1'b1;
            err       <= 1'b0;
            st        <= S_TXOFF;
          end else begin
            err <= 1'b1;
          end
        end
        S_TXOFF: begin
          tx_pwr_on <= 1'b0;
          st        <= S_PDON;
        end
        S_PDON: begin
          pddq <= 1'b1;
          st   <= S_RETLO;
        end
        S_RETLO: begin
          svsret <= 1'b0;
          cnt    <= gen1_q ? CW'(HOLD_G1 - 1) : CW'(HOLD_G2 - 1);
          st     <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt == '0) begin
            svsret <= ret_use_q;
            st     <= S_REL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REL: begin
          rst_on  <= 1'b0;
          cfg_req <= 1'b1;
          st      <= S_CFGW;
        end
        S_CFGW: begin
          cfg_req <= 1'b0;
          if (cfg_done) begin
            pddq <= 1'b0;
            st   <= S_TXON;
          end
        end
        S_TXON: begin
          tx_pwr_on <= 1'b1;
          cnt       <= CW'(LOCK_WAIT);
          st        <= S_LOCK;
        end
        S_LOCK: begin
          if (pll_lock) begin
            st <= S_ON;
          end else if (cnt == '0) begin
            err       <= 1'b1;
            tx_pwr_on <= 1'b0;
            pddq      <= 1'b1;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ON: if (stop) begin
          tx_pwr_on <= 1'b0;
          st        <= S_DNPD;
        end
        S_DNPD: begin
          pddq <= 1'b1;
          cnt  <= CW'(READY_WAIT);
          st   <= S_DNWAIT;
        end
        S_DNWAIT: begin
          if (!tx_ready) begin
            if (ret_drop_en) svsret <= 1'b0;
            st <= S_IDLE;
          end else if (cnt == '0) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       stop,
  input logic [7:0] type_id,
  input logic       pll_lock,
  input logic       tx_ready,
  input logic       cfg_done,
  input logic       ret_drop_en,
  input logic       phy_rst,
  input logic       tx_pwr_on,
  input logic       pddq,
  input logic       svsret,
  input logic       cfg_req,
  input logic       powered,
  input logic       busy,
  input logic       err
);

  logic known_id;
  assign known_id = (type_id == 8'h00) || (type_id == 8'hB2) || (type_id == 8'hC2) ||
                    (type_id == 8'hE2) || (type_id == 8'hF2) || (type_id == 8'hF3);

  a_r3_ret_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $stable(svsret));

  a_r6_bad_id_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !powered && !known_id) |=> (err && !busy && !powered));

  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> !cfg_req);

  a_r7_req_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (busy && pddq && !tx_pwr_on));

  a_r8_txon_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pwr_on) |-> (!pddq && busy));

  a_r8_powered_pins: assert property (@(posedge clk) disable iff (!rst_n)
    powered |-> (tx_pwr_on && !pddq));

  a_r10_ret_drop_late: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(svsret) && !busy) |-> (pddq && !tx_pwr_on && !$past(tx_ready)));

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, powered}));

  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && powered) |=> powered);

  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (.*);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int H1 = 4, H2 = 6, LW = 20, RW = 20;

  logic clk = 0, rst_n = 0, start = 0, stop = 0, cfg_done = 0, ret_drop_en = 0;
  logic [7:0] type_id = 8'h00;
  logic pll_lock, tx_ready;
  logic phy_rst, tx_pwr_on, pddq, svsret, cfg_req, powered, busy, err;
  logic lock_ok = 1, stuck_ready = 0;
  logic [2:0] rsh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_pwr_seq #(.HOLD_G1(H1), .HOLD_G2(H2), .LOCK_WAIT(LW), .READY_WAIT(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .type_id(type_id),
    .pll_lock(pll_lock), .tx_ready(tx_ready), .cfg_done(cfg_done),
    .ret_drop_en(ret_drop_en), .phy_rst(phy_rst), .tx_pwr_on(tx_pwr_on),
    .pddq(pddq), .svsret(svsret), .cfg_req(cfg_req), .powered(powered),
    .busy(busy), .err(err));

  assign pll_lock = lock_ok & tx_pwr_on;
  assign tx_ready = rsh[2] | stuck_ready;

  int checks = 0, fails = 0, cyc = 0, cd = 0;
  int t_busy = 0, t_rst = 0, t_tx = 0, t_pd = 0, t_err = 0;
  logic [7:0] eq[$];
  string et[$];
  logic [7:0] ov, prev;
  assign ov = {phy_rst, tx_pwr_on, pddq, svsret, cfg_req, powered, busy, err};

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic exp(input logic [7:0] v, input string tag);
    eq.push_back(v);
    et.push_back(tag);
  endtask

  always @(negedge clk) begin
    rsh = {rsh[1:0], tx_pwr_on & ~pddq};
    cfg_done = 0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) cfg_done = 1;
    end else if (cfg_req) cd = 2;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && ov !== prev) begin
      if (busy && !prev[1]) t_busy = cyc;
      if (busy && phy_rst !== prev[7]) t_rst = cyc;
      if (tx_pwr_on && !prev[6]) t_tx = cyc;
      if (pddq && !prev[5]) t_pd = cyc;
      if (err && !prev[0]) t_err = cyc;
      if (eq.size() == 0) check(0, "R12 unexpected output change", ov, prev);
      else begin
        logic [7:0] e;
        string t;
        e = eq.pop_front();
        t = et.pop_front();
        check(ov === e, t, ov, e);
      end
    end
    prev = ov;
  end

  task automatic do_start(input logic [7:0] id);
    @(negedge clk); type_id = id; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (eq.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(eq.size() == 0, tag, eq.size(), 0);
    eq.delete();
    et.delete();
  endtask

  task automatic up_f3();
    exp(8'b0011_1010, "R2 release with cfg_req");
    exp(8'b0011_0010, "R7 cfg_req one cycle");
    exp(8'b0001_0010, "R2 pddq low after cfg_done");
    exp(8'b0101_0010, "R8 tx on after pddq low");
    exp(8'b0101_0100, "R8 powered after lock");
  endtask

  bit done = 0;

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(ov === 8'b0010_0000, "R1 reset state", ov, 8'b0010_0000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(ov === 8'b0010_0000, "R1 state after reset release", ov, 8'b0010_0000);

    exp(8'b1010_0010, "R2 reset asserted busy");
    exp(8'b1011_0010, "R5 svsret raised for 0xF3");
    up_f3();
    do_start(8'hF3);
    drain("R2 power-up sequence 0xF3");
    check(t_rst - t_busy == H2 + 4, "R4 gen2 reset hold", t_rst - t_busy, H2 + 4);

    do_start(8'hFE);
    repeat (5) @(negedge clk);
    check(powered === 1 && err === 0, "R12 start ignored while powered", {powered, err}, 2'b10);

    exp(8'b0001_0010, "R10 tx off first");
    exp(8'b0011_0010, "R10 pddq high second");
    exp(8'b0011_0000, "R10 idle, svsret kept");
    do_stop();
    drain("R10 power-down keep retention");

    exp(8'b1011_0010, "R2 reset asserted again");
    exp(8'b1010_0010, "R2 svsret low step");
    exp(8'b1011_0010, "R3 svsret high before release");
    up_f3();
    do_start(8'hF3);
    repeat (2) @(negedge clk);
    type_id = 8'h00; start = 1; stop = 1;
    @(negedge clk); start = 0; stop = 0;
    drain("R12 commands ignored while busy");

    ret_drop_en = 1;
    exp(8'b0001_0010, "R10 tx off");
    exp(8'b0011_0010, "R10 pddq high");
    exp(8'b0010_0000, "R10 svsret dropped after tx_ready low");
    do_stop();
    drain("R10 power-down with retention drop");

    exp(8'b0010_0010, "R4 gen1 reset asserted low");
    exp(8'b1010_1010, "R4 gen1 release drives high");
    exp(8'b1010_0010, "R7 cfg_req one cycle");
    exp(8'b1000_0010, "R2 pddq low");
    exp(8'b1100_0010, "R8 tx on");
    exp(8'b1100_0100, "R5 powered, svsret low for 0x00");
    do_start(8'h00);
    drain("R4 gen1 power-up");
    check(t_rst - t_busy == H1 + 4, "R4 gen1 reset hold", t_rst - t_busy, H1 + 4);
    check(phy_rst === 1, "R4 gen1 released level", phy_rst, 1);

    ret_drop_en = 0;
    exp(8'b1000_0010, "R10 tx off");
    exp(8'b1010_0010, "R10 pddq high");
    exp(8'b1010_0000, "R10 idle");
    do_stop();
    drain("R10 gen1 power-down");
    do_stop();
    repeat (4) @(negedge clk);
    check(ov === 8'b1010_0000, "R12 stop ignored in idle", ov, 8'b1010_0000);

    exp(8'b1010_0001, "R6 vendor id sets err");
    do_start(8'hFE);
    drain("R6 vendor id");
    do_start(8'h55);
    repeat (4) @(negedge clk);
    check(ov === 8'b1010_0001, "R6 unlisted id stays idle", ov, 8'b1010_0001);

    lock_ok = 0;
    exp(8'b1010_0010, "R13 err cleared by accepted start");
    exp(8'b1011_0010, "R5 svsret raised for 0xC2");
    exp(8'b0011_1010, "R2 release");
    exp(8'b0011_0010, "R7 cfg_req one cycle");
    exp(8'b0001_0010, "R2 pddq low");
    exp(8'b0101_0010, "R8 tx on");
    exp(8'b0011_0001, "R9 lock timeout powers off");
    do_start(8'hC2);
    drain("R9 lock timeout");
    check(t_err - t_tx == LW + 1, "R9 lock timeout delay", t_err - t_tx, LW + 1);
    lock_ok = 1;

    exp(8'b1011_0010, "R13 err cleared");
    exp(8'b1010_0010, "R2 svsret low step");
    exp(8'b0010_1010, "R5 release, svsret low for 0xE2");
    exp(8'b0010_0010, "R7 cfg_req one cycle");
    exp(8'b0000_0010, "R2 pddq low");
    exp(8'b0100_0010, "R8 tx on");
    exp(8'b0100_0100, "R8 powered");
    do_start(8'hE2);
    drain("R5 power-up 0xE2");

    stuck_ready = 1;
    exp(8'b0000_0010, "R10 tx off");
    exp(8'b0010_0010, "R10 pddq high");
    exp(8'b0010_0001, "R11 ready timeout");
    do_stop();
    drain("R11 ready timeout");
    check(t_err - t_pd == RW + 1, "R11 ready timeout delay", t_err - t_pd, RW + 1);
    stuck_ready = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule